// File: doc/BRIEF.md
# Strobed DRAM Array with Row Latch

This block is a synthesizable behavioural model of a small single-bit dynamic memory: 8 rows of 8 cells reached through one shared 3-bit address bus. The row and column addresses arrive at different times on the same bus. A row strobe captures the row address, and a column strobe captures the column address. A write enable sampled with the column strobe chooses between reading and writing. All strobes are active high and are sampled on the rising clock edge. A rising edge of a strobe is a sample at 1 that follows a sample at 0.

Opening a row is destructive. The whole row is copied into a row latch, which plays the part of the sense amplifiers, and the cells of that row are left holding the bitwise inverse of their contents. Column accesses read or write only the latch. Releasing the row strobe writes the latch back into the row, which restores and refreshes it. A precharge interval then follows. Misplaced strobes are ignored and reported on a one-cycle error pulse.

The controller is a state machine with five states:
- `ST_IDLE`: bit lines are precharged and the block waits for a row.
- `ST_ROW_OPEN`: a row is held in the latch and the column strobe is low.
- `ST_COL_ACCESS`: a column access is in progress.
- `ST_RESTORE`: one cycle in which the latch is written back into the row.
- `ST_PRECHARGE`: `PRE_CYC` cycles of precharge.

The transitions are:
- *activate*: `ST_IDLE` to `ST_ROW_OPEN` on a rising row strobe.
- *column strobe*: `ST_ROW_OPEN` to `ST_COL_ACCESS` on a rising column strobe while the row strobe is high.
- *column end*: `ST_COL_ACCESS` to `ST_ROW_OPEN` when the column strobe is low.
- *row release*: `ST_ROW_OPEN` or `ST_COL_ACCESS` to `ST_RESTORE` when the row strobe is low. Row release takes priority over the other transitions.
- *write-back*: `ST_RESTORE` to `ST_PRECHARGE`.
- *precharge done*: `ST_PRECHARGE` to `ST_IDLE` when the precharge count runs out.

Top module: `dram_strobe_array`

## Requirements
- R1: After reset, `rd_bit` and `proto_err` are 0 and the controller is in `ST_IDLE`, ready to accept a row strobe. Reset does not clear the cell array.
- R2: A rising row strobe in `ST_IDLE` latches `mux_addr` as the row. A later rising column strobe latches `mux_addr` as the column. With `wr_en` at 0, `rd_bit` shows the stored bit from the next cycle for as long as the column strobe stays high.
- R3: `rd_bit` is 0 in every state except a read column access. This includes a write access, an open row with the column strobe low, restore, precharge and idle.
- R4: With `wr_en` at 1 at the column strobe, `wr_bit` is written into the selected column of the open row. The other seven bits of that row are unchanged after the row closes.
- R5: Several column strobes may occur within one row strobe. A read that follows a write in the same row strobe returns the newly written bit.
- R6: When the row strobe is sampled low with a row open, the latch is written back in one `ST_RESTORE` cycle, followed by `PRE_CYC` (default 2) precharge cycles. Data survives any number of activate and restore cycles. A rising row strobe is accepted at the earliest on the fourth edge after the edge at which the row strobe was sampled low.
- R7: Activating a row leaves that row's cells holding the inverse of their previous value until restore. If reset aborts an open row, the row keeps the inverted pattern, and later reads return the complement of the old data.
- R8: A rising column strobe with no open row is ignored and produces a one-cycle `proto_err` pulse with no cell change. This covers `ST_IDLE`, `ST_RESTORE`, `ST_PRECHARGE`, and the same edge at which the row strobe is released.
- R9: A rising row strobe during `ST_RESTORE` or `ST_PRECHARGE` is ignored, so no row opens, and produces a one-cycle `proto_err` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; controller and latch only |
| mux_addr | input | 3 | Shared bus carrying the row address, then the column address |
| row_strobe | input | 1 | Row address strobe, active high |
| col_strobe | input | 1 | Column address strobe, active high |
| wr_en | input | 1 | 1 at the column strobe selects a write, 0 selects a read |
| wr_bit | input | 1 | Data bit to write |
| rd_bit | output | 1 | Read data, 0 outside a read column access |
| proto_err | output | 1 | One-cycle pulse on an ignored strobe |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is row release and a column write. The bench drops the row strobe and raises the column strobe, with write enable set and inverted data, on the same edge. The verdict is an error pulse, a zero read output, and a later read showing the cell unchanged.

The second pair is the end of precharge and a new activation. The bench raises the row strobe in the last precharge cycle. It confirms that the strobe is refused with an error pulse. A column strobe that follows must also error, which shows that no row was opened. Exhaustive write, read and single-cell flip sweeps cover all 64 cells, and a reset during an open row exposes the inverted row.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ROW_OPEN   = 3'd1,
        ST_COL_ACCESS = 3'd2,
        ST_RESTORE    = 3'd3,
        ST_PRECHARGE  = 3'd4
    } dsa_state_e;

endpackage

// File: rtl/dsa_ctrl.sv
module dsa_ctrl
    import dsa_pkg::*;
#(
    parameter int ROW_AW  = 3,
    parameter int COL_AW  = 3,
    parameter int ADDR_W  = 3,
    parameter int PRE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras,
    input  logic              cas,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output dsa_state_e        state,
    output logic              act,
    output logic              col_wr,
    output logic              restore,
    output logic [ROW_AW-1:0] row_ptr,
    output logic [COL_AW-1:0] col_q,
    output logic              rd_en,
    output logic              proto_err
);

    localparam int CNT_W = (PRE_CYC < 2) ? 1 : $clog2(PRE_CYC + 1);

    dsa_state_e        state_n;
    logic              ras_q, cas_q;
    logic              ras_rise, cas_rise;
    logic [ROW_AW-1:0] row_q;
    logic              rd_mode;
    logic [CNT_W-1:0]  pre_cnt;
    logic              col_take;
    logic              err_n;

    assign ras_rise = ras & ~ras_q;
    assign cas_rise = cas & ~cas_q;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:       if (ras_rise) state_n = ST_ROW_OPEN;
            ST_ROW_OPEN: begin
                if (!ras)          state_n = ST_RESTORE;
                else if (cas_rise) state_n = ST_COL_ACCESS;
            end
            ST_COL_ACCESS: begin
                if (!ras)      state_n = ST_RESTORE;
                else if (!cas) state_n = ST_ROW_OPEN;
            end
            ST_RESTORE:    state_n = ST_PRECHARGE;
            ST_PRECHARGE:  if (pre_cnt == '0) state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
    end

    // event strobes and protocol checks
    always_comb begin
        act      = 1'b0;
        col_take = 1'b0;
        restore  = 1'b0;
        err_n    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                act   = ras_rise;
                err_n = cas_rise;
            end
            ST_ROW_OPEN: begin
                col_take = ras & cas_rise;
                err_n    = ~ras & cas_rise;
            end
            ST_COL_ACCESS: ;
            ST_RESTORE: begin
                restore = 1'b1;
                err_n   = ras_rise | cas_rise;
            end
            ST_PRECHARGE: err_n = ras_rise | cas_rise;
            default: ;
        endcase
    end

    assign col_wr  = col_take & we;
    assign row_ptr = act ? addr[ROW_AW-1:0] : row_q;

    // state register and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ras_q     <= 1'b0;
            cas_q     <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            rd_mode   <= 1'b0;
            pre_cnt   <= '0;
            proto_err <= 1'b0;
        end else begin
            state     <= state_n;
            ras_q     <= ras;
            cas_q     <= cas;
            proto_err <= err_n;
            if (act) row_q <= addr[ROW_AW-1:0];
            if (col_take) begin
                col_q   <= addr[COL_AW-1:0];
                rd_mode <= ~we;
            end
            if (state == ST_RESTORE)
                pre_cnt <= CNT_W'(PRE_CYC - 1);
            else if (state == ST_PRECHARGE && pre_cnt != '0)
                pre_cnt <= pre_cnt - 1'b1;
        end
    end

    // output process
    always_comb begin
        rd_en = 1'b0;
        unique case (state)
            ST_COL_ACCESS: rd_en = rd_mode;
            ST_IDLE, ST_ROW_OPEN, ST_RESTORE, ST_PRECHARGE: rd_en = 1'b0;
            default: rd_en = 1'b0;
        endcase
    end

    // R6: row release always leads into restore, then precharge
    p_release_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ROW_OPEN || state == ST_COL_ACCESS) && !ras) |=> (state == ST_RESTORE));
    p_restore_prech_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESTORE) |=> (state == ST_PRECHARGE));
    // R9: no activation straight out of precharge; a strobe there errors
    p_no_act_prech_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRECHARGE) |=> (state != ST_ROW_OPEN));
    p_prech_ras_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRECHARGE && ras && !ras_q) |=> proto_err);
    // R8: column strobe with no row errors
    p_idle_cas_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cas && !cas_q) |=> (proto_err && state != ST_COL_ACCESS));
    // R3: read data only ever follows a held row strobe
    p_rd_needs_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(ras));

endmodule

// File: rtl/dsa_row_decoder.sv
module dsa_row_decoder #(
    parameter int ROW_AW = 3,
    parameter int NROWS  = 1 << ROW_AW
) (
    input  logic [ROW_AW-1:0] row_ptr,
    output logic [NROWS-1:0]  wl
);

    for (genvar i = 0; i < NROWS; i++) begin : g_wl
        assign wl[i] = (row_ptr == ROW_AW'(i));
    end

endmodule

// File: rtl/dsa_cell_array.sv
module dsa_cell_array #(
    parameter int NROWS = 8,
    parameter int NCOLS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NROWS-1:0] wl,
    input  logic             disturb,
    input  logic             restore,
    input  logic [NCOLS-1:0] wdata,
    output logic [NCOLS-1:0] rd_row
);

    // storage cells carry no reset: they model charge, not control state
    logic [NROWS-1:0][NCOLS-1:0] cells;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NROWS; i++) begin
            if (wl[i]) begin
                if (disturb)      cells[i] <= ~cells[i];
                else if (restore) cells[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_row = '0;
        for (int i = 0; i < NROWS; i++)
            if (wl[i]) rd_row = rd_row | cells[i];
    end

    // R6: outside activate and restore no cell changes
    p_cells_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!disturb && !restore) |=> (cells === $past(cells)));

endmodule

// File: rtl/dsa_row_latch.sv
module dsa_row_latch #(
    parameter int NCOLS  = 8,
    parameter int COL_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NCOLS-1:0]  row_in,
    input  logic              wr,
    input  logic [COL_AW-1:0] wr_col,
    input  logic              wr_bit,
    input  logic [COL_AW-1:0] rd_col,
    input  logic              rd_en,
    output logic [NCOLS-1:0]  bits,
    output logic              data_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (load) begin
            bits <= row_in;
        end else if (wr) begin
            bits[wr_col] <= wr_bit;
        end
    end

    // column multiplexer into the data buffer
    assign data_out = rd_en ? bits[rd_col] : 1'b0;

    // R4: a write touches at most one latch bit
    p_one_bit_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ($countones(bits ^ $past(bits)) <= 1));
    // R4: without load or write, the latch holds
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !load) |=> $stable(bits));

endmodule

// File: rtl/dram_strobe_array.sv
module dram_strobe_array
    import dsa_pkg::*;
#(
    parameter int ROW_AW  = 3,
    parameter int COL_AW  = 3,
    parameter int PRE_CYC = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [((ROW_AW > COL_AW) ? ROW_AW : COL_AW)-1:0] mux_addr,
    input  logic                                         row_strobe,
    input  logic                                         col_strobe,
    input  logic                                         wr_en,
    input  logic                                         wr_bit,
    output logic                                         rd_bit,
    output logic                                         proto_err
);

    localparam int ADDR_W = (ROW_AW > COL_AW) ? ROW_AW : COL_AW;
    localparam int NROWS  = 1 << ROW_AW;
    localparam int NCOLS  = 1 << COL_AW;

    dsa_state_e        state;
    logic              act, col_wr, restore, rd_en;
    logic [ROW_AW-1:0] row_ptr;
    logic [COL_AW-1:0] col_q;
    logic [NROWS-1:0]  wl;
    logic [NCOLS-1:0]  arr_row, latch_bits;

    dsa_ctrl #(
        .ROW_AW (ROW_AW),
        .COL_AW (COL_AW),
        .ADDR_W (ADDR_W),
        .PRE_CYC(PRE_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras      (row_strobe),
        .cas      (col_strobe),
        .we       (wr_en),
        .addr     (mux_addr),
        .state    (state),
        .act      (act),
        .col_wr   (col_wr),
        .restore  (restore),
        .row_ptr  (row_ptr),
        .col_q    (col_q),
        .rd_en    (rd_en),
        .proto_err(proto_err)
    );

    dsa_row_decoder #(
        .ROW_AW(ROW_AW),
        .NROWS (NROWS)
    ) u_dec (
        .row_ptr(row_ptr),
        .wl     (wl)
    );

    dsa_cell_array #(
        .NROWS(NROWS),
        .NCOLS(NCOLS)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .wl     (wl),
        .disturb(act),
        .restore(restore),
        .wdata  (latch_bits),
        .rd_row (arr_row)
    );

    dsa_row_latch #(
        .NCOLS (NCOLS),
        .COL_AW(COL_AW)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (act),
        .row_in  (arr_row),
        .wr      (col_wr),
        .wr_col  (mux_addr[COL_AW-1:0]),
        .wr_bit  (wr_bit),
        .rd_col  (col_q),
        .rd_en   (rd_en),
        .bits    (latch_bits),
        .data_out(rd_bit)
    );

    // R7: right after activation the opened row holds the inverse of the latch
    p_disturb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_OPEN && $past(state) == ST_IDLE) |-> (arr_row === ~latch_bits));

endmodule

// File: tb/sim_dram_strobe_array.sv
module sim_dram_strobe_array;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mux_addr;
    logic       row_strobe, col_strobe, wr_en, wr_bit;
    logic       rd_bit, proto_err;

    always #4 clk = ~clk;  // 125 MHz

    dram_strobe_array u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mux_addr  (mux_addr),
        .row_strobe(row_strobe),
        .col_strobe(col_strobe),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .rd_bit    (rd_bit),
        .proto_err (proto_err)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic exp_mem [8][8];

    function automatic logic pat(int r, int c);
        return ((r * 3 + c * 5) % 4) < 2;
    endfunction

    task automatic chk(string req, logic got, logic expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, expv);
        end
    endtask

    task automatic open_row(int r);
        @(negedge clk);
        mux_addr   = 3'(r);
        row_strobe = 1'b1;
    endtask

    task automatic access(int c, logic w, logic d, output logic b);
        @(negedge clk);
        mux_addr   = 3'(c);
        col_strobe = 1'b1;
        wr_en      = w;
        wr_bit     = d;
        @(negedge clk);
        b          = rd_bit;
        col_strobe = 1'b0;
        wr_en      = 1'b0;
    endtask

    // release: restore plus two precharge cycles before the next strobe
    task automatic close_row();
        @(negedge clk);
        chk("R3 dout with row open and column strobe low", rd_bit, 1'b0);
        row_strobe = 1'b0;
        col_strobe = 1'b0;
        wr_en      = 1'b0;
        @(negedge clk);
        chk("R3 dout during restore", rd_bit, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_row(int r, string req);
        logic b;
        open_row(r);
        for (int c = 0; c < 8; c++) begin
            access(c, 1'b0, 1'b0, b);
            chk(req, b, exp_mem[r][c]);
        end
        close_row();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic b;
        rst_n      = 1'b0;
        mux_addr   = '0;
        row_strobe = 1'b0;
        col_strobe = 1'b0;
        wr_en      = 1'b0;
        wr_bit     = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 dout after reset", rd_bit, 1'b0);
        chk("R1 proto_err after reset", proto_err, 1'b0);

        // R4: fill every cell, one row per strobe, write accesses show 0
        for (int r = 0; r < 8; r++) begin
            open_row(r);
            for (int c = 0; c < 8; c++) begin
                exp_mem[r][c] = pat(r, c);
                access(c, 1'b1, exp_mem[r][c], b);
                chk("R3 dout during write access", b, 1'b0);
            end
            close_row();
        end

        // R2: one strobe pair per cell; R6: data survives repeated restores
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                open_row(r);
                access(c, 1'b0, 1'b0, b);
                chk("R2 single read", b, exp_mem[r][c]);
                close_row();
            end
        end
        for (int r = 0; r < 8; r++) read_row(r, "R6 data after refresh cycles");

        // R4/R5: flip each cell alone, read it back under the same strobe
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                open_row(r);
                exp_mem[r][c] = ~exp_mem[r][c];
                access(c, 1'b1, exp_mem[r][c], b);
                access(c, 1'b0, 1'b0, b);
                chk("R5 read after write same row strobe", b, exp_mem[r][c]);
                close_row();
                read_row(r, "R4 single-bit write, neighbours kept");
            end
        end

        // R5: burst of writes then reads under one row strobe
        open_row(7);
        for (int c = 0; c < 8; c++) begin
            exp_mem[7][c] = ~exp_mem[7][c];
            access(c, 1'b1, exp_mem[7][c], b);
        end
        for (int c = 7; c >= 0; c--) begin
            access(c, 1'b0, 1'b0, b);
            chk("R5 page-mode burst read", b, exp_mem[7][c]);
        end
        close_row();
        read_row(7, "R5 burst kept after restore");

        // R8: column strobe while idle
        @(negedge clk);
        mux_addr   = 3'd0;
        col_strobe = 1'b1;
        wr_en      = 1'b1;
        wr_bit     = ~exp_mem[0][0];
        @(negedge clk);
        chk("R8 error on idle column strobe", proto_err, 1'b1);
        chk("R3 dout on ignored column strobe", rd_bit, 1'b0);
        col_strobe = 1'b0;
        wr_en      = 1'b0;
        @(negedge clk);
        chk("R8 error is a single pulse", proto_err, 1'b0);
        read_row(0, "R8 idle column strobe changed nothing");

        // R9/R6: row strobe in last precharge cycle is refused
        open_row(2);
        access(1, 1'b0, 1'b0, b);
        chk("R2 read before precharge test", b, exp_mem[2][1]);
        @(negedge clk);
        row_strobe = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 dout during precharge", rd_bit, 1'b0);
        mux_addr   = 3'd4;
        row_strobe = 1'b1;
        @(negedge clk);
        chk("R9 error on row strobe in precharge", proto_err, 1'b1);
        row_strobe = 1'b0;
        @(negedge clk);
        chk("R9 error is a single pulse", proto_err, 1'b0);
        col_strobe = 1'b1;
        mux_addr   = 3'd0;
        @(negedge clk);
        chk("R9 refused strobe opened no row", proto_err, 1'b1);
        chk("R9 no read from refused row", rd_bit, 1'b0);
        col_strobe = 1'b0;
        @(negedge clk);
        read_row(4, "R6 row accepted after precharge");
        read_row(2, "R6 row restored before refused strobe");

        // R8: release and column write on the same edge
        open_row(5);
        @(negedge clk);
        row_strobe = 1'b0;
        mux_addr   = 3'd3;
        col_strobe = 1'b1;
        wr_en      = 1'b1;
        wr_bit     = ~exp_mem[5][3];
        @(negedge clk);
        chk("R8 error on column strobe at row release", proto_err, 1'b1);
        chk("R3 dout at collided column strobe", rd_bit, 1'b0);
        col_strobe = 1'b0;
        wr_en      = 1'b0;
        @(negedge clk);
        chk("R8 collision pulse ends", proto_err, 1'b0);
        @(negedge clk);
        read_row(5, "R8 collided write discarded");

        // R7: reset aborts an open row, which stays inverted
        open_row(6);
        @(negedge clk);
        row_strobe = 1'b0;
        rst_n      = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 dout after mid-row reset", rd_bit, 1'b0);
        chk("R1 proto_err after mid-row reset", proto_err, 1'b0);
        for (int c = 0; c < 8; c++) exp_mem[6][c] = ~exp_mem[6][c];
        read_row(6, "R7 aborted row reads inverted");
        read_row(6, "R7 inverted row stable after restore");
        read_row(3, "R7 other rows untouched by abort");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule